// File: doc/BRIEF.md
# Quarter-Wave Sine Sample Generator

This block produces a repeating 24-bit signed sine sequence for an audio transmitter. The transmitter raises a one-cycle sample-enable strobe each time it wants a new sample. On each strobe the block emits the sample for its current phase step and then moves to the next step. One period is 16 steps, so the tone frequency is the strobe rate divided by 16.

Only the rising first quarter of the wave is held, as five magnitudes computed when the design elaborates. Phase steps past the crest read the table at a mirrored address. Steps in the second half of the period take the negated value. The output is registered and carries a valid flag.

Top module: `qsine_gen`

## Requirements
- R1: While reset is asserted, and after reset until the first enable, valid_o is 0 and sample_o is 0. The first enable after reset produces the sample for phase step 0.
- R2: valid_o is 1 in exactly the clock cycle that follows a cycle with en_i high, and 0 in every other cycle.
- R3: The sample produced for phase step k (0..15) equals round(8388607 * sin(k*pi/8)), rounded half away from zero.
- R4: Each enable advances the phase step by one. The step wraps from 15 to 0, so 16 enables form one period.
- R5: In cycles without an enable, the phase step does not change and sample_o keeps its previous value.
- R6: Step 4 yields +8388607 and step 12 yields -8388607. The value -8388608 never appears on sample_o.
- R7: For k in 0..7, the sample for step k+8 is the two's-complement negation of the sample for step k.
- R8: For k in 1..3, the sample for step 8-k equals the sample for step k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Sample-enable strobe from the transmitter |
| valid_o | output | 1 | High for one cycle when a new sample is presented |
| sample_o | output | 24 | Signed sine sample, two's complement |

## Verification
A sample is due exactly one clock after the enable that requests it. Its valid flag rises on that same edge. The bench drives en_i on the falling edge and keeps a behavioural model that advances at each rising edge. At every falling edge it compares valid_o, and also sample_o, including the held value in idle cycles. The enable is driven in four ways: held high continuously, one strobe every third cycle, a pseudo-random pattern, and a reset in the middle of a period. Together these reach every phase step, the wrap from step 15 to step 0, and long idle gaps.

// File: rtl/qsine_pkg.sv
package qsine_pkg;
  localparam real PI = 3.14159265358979323846;

  // magnitude of quarter-table entry k: round(amp * sin(k*pi/(2*steps_q)))
  function automatic int quarter_val(input int k, input int steps_q, input int amp);
    real r;
    r = real'(amp) * $sin(PI * real'(k) / real'(2 * steps_q));
    return $rtoi(r + 0.5);
  endfunction
endpackage

// File: rtl/qsine_phase.sv
module qsine_phase #(
  parameter int PHASE_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  output logic [PHASE_W-1:0] phase_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   phase_o <= '0;
    else if (en_i) phase_o <= phase_o + 1'b1;
  end

  p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> phase_o == $past(phase_o) + 1'b1);
  p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(phase_o));
endmodule

// File: rtl/qsine_fold.sv
module qsine_fold #(
  parameter int PHASE_W = 4,
  parameter int ADDR_W  = 3
) (
  input  logic [PHASE_W-1:0] phase_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic               neg_o
);
  localparam int QN = 1 << (PHASE_W - 2);

  logic [PHASE_W-2:0] half;

  always_comb begin
    half  = phase_i[PHASE_W-2:0];
    neg_o = phase_i[PHASE_W-1];
    if (int'(half) > QN) addr_o = ADDR_W'(2 * QN - int'(half));  // past the crest: mirror
    else                 addr_o = ADDR_W'(half);
  end

  always_comb begin
    p_addr_range_r8: assert (int'(addr_o) <= QN);
  end
endmodule

// File: rtl/qsine_rom.sv
module qsine_rom #(
  parameter int PHASE_W  = 4,
  parameter int ADDR_W   = 3,
  parameter int SAMPLE_W = 24
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [SAMPLE_W-1:0] mag_o
);
  localparam int QN  = 1 << (PHASE_W - 2);
  localparam int AMP = (1 << (SAMPLE_W - 1)) - 1;

  logic [SAMPLE_W-1:0] tbl [QN+1];

  for (genvar g = 0; g <= QN; g++) begin : g_tbl
    assign tbl[g] = SAMPLE_W'(qsine_pkg::quarter_val(g, QN, AMP));
  end

  always_comb begin
    if (int'(addr_i) <= QN) mag_o = tbl[addr_i];
    else                    mag_o = '0;
  end
endmodule

// File: rtl/qsine_gen.sv
module qsine_gen #(
  parameter int PHASE_W  = 4,
  parameter int SAMPLE_W = 24
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       en_i,
  output logic                       valid_o,
  output logic signed [SAMPLE_W-1:0] sample_o
);
  localparam int QN     = 1 << (PHASE_W - 2);
  localparam int ADDR_W = $clog2(QN + 1);

  logic [PHASE_W-1:0]  phase;
  logic [ADDR_W-1:0]   addr;
  logic                neg;
  logic [SAMPLE_W-1:0] mag;

  qsine_phase #(.PHASE_W(PHASE_W)) u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .phase_o(phase));

  qsine_fold #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W)) u_fold (
    .phase_i(phase), .addr_o(addr), .neg_o(neg));

  qsine_rom #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W)) u_rom (
    .addr_i(addr), .mag_o(mag));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      sample_o <= '0;
    end else begin
      valid_o <= en_i;
      if (en_i) sample_o <= neg ? -$signed(mag) : $signed(mag);
    end
  end

  p_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> valid_o);
  p_no_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !valid_o);
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(sample_o));
  p_no_min_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o != {1'b1, {(SAMPLE_W-1){1'b0}}});
  p_sign_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && neg && mag != '0) |=> sample_o < 0);
endmodule

// File: tb/qsine_gen_test.sv
module qsine_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic valid;
  logic signed [23:0] sample;

  int checks = 0;
  int errors = 0;
  int ph = 0;
  int exp_sample = 0;
  bit exp_valid = 1'b0;
  bit done = 1'b0;
  int lfsr = 16'hACE1;

  always #5 clk = ~clk;

  qsine_gen uut (.clk_i(clk), .rst_ni(rst_n), .en_i(en), .valid_o(valid), .sample_o(sample));

  function automatic int ref_val(input int k);
    real r;
    r = 8388607.0 * $sin(3.14159265358979323846 * real'(k) / 8.0);
    if (r >= 0.0) return $rtoi(r + 0.5);
    return -$rtoi(-r + 0.5);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // compare outputs at the falling edge, then drive the next enable and update the model
  task automatic cycle(input bit e);
    @(negedge clk);
    check("R2", int'(valid), int'(exp_valid));
    check("R3/R5", int'(sample), exp_sample);
    if (sample == -24'sd8388608) check("R6", int'(sample), -8388607);
    en = e;
    exp_valid = e;
    if (e) begin
      exp_sample = ref_val(ph);
      ph = (ph + 1) % 16;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    en = 1'b0;
    #1;
    check("R1 valid", int'(valid), 0);
    check("R1 sample", int'(sample), 0);
    ph = 0; exp_sample = 0; exp_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    // fixed points and symmetry of the reference, independent of the design
    check("R6 step4", ref_val(4), 8388607);
    check("R6 step12", ref_val(12), -8388607);
    for (int k = 0; k < 8; k++) check("R7", ref_val(k + 8), -ref_val(k));
    for (int k = 1; k < 4; k++) check("R8", ref_val(8 - k), ref_val(k));

    do_reset();
    // R1: idle after reset keeps zero
    for (int i = 0; i < 3; i++) cycle(1'b0);
    // R3/R4: continuous enables, two and a half periods
    for (int i = 0; i < 40; i++) cycle(1'b1);
    cycle(1'b0);
    // R5: strobe every third cycle
    for (int i = 0; i < 60; i++) cycle(i % 3 == 0);
    // pseudo-random enable pattern
    for (int i = 0; i < 400; i++) begin
      lfsr = ((lfsr >> 1) ^ ((lfsr & 1) ? 16'hB400 : 0)) & 16'hFFFF;
      cycle(lfsr[0]);
    end
    // R1/R4: reset in the middle of a period restarts at step 0
    do_reset();
    for (int i = 0; i < 20; i++) cycle(1'b1);
    for (int i = 0; i < 3; i++) cycle(1'b0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule